// File: doc/BRIEF.md
# Frame-Synchronous Exposure and Gain Shadow Registers

This block sits between a register write port and the timing logic of an image sensor core. Software writes a five-byte page of exposure parameters: coarse integration time, fine integration time, a 4-bit clock divider and the analog gain. These bytes land in holding registers, which read back exactly as written. The values the core actually uses change only on a frame-start pulse. At that pulse the holding set is clipped to its legal range and copied to the active outputs.

Gain acts at the output stage, but integration time acts on the array one frame earlier. For that reason the active gain is moved one frame-start later than the exposure fields it belongs to, so both reach the same output frame.

A write burst into the page holds off the copy until the burst is closed. A burst is closed by a bus STOP pulse or by a write to an address outside the page. This way the core never takes a half-updated set. The write port is a valid/ready stream whose ready is always high. Every beat presented with valid is accepted on that clock edge, so the port never applies back-pressure.

Top module: `exp_shadow_sync`

## Requirements
- R1: Active coarse, fine and clock-divide outputs change only in the cycle after a frame-start pulse. They then take the holding values, provided an update is pending and no burst is open.
- R2: The active gain output changes only in the cycle after a frame-start pulse. It takes the gain captured at the previous transfer, so it lags the exposure fields by exactly one frame start.
- R3: The page is five byte addresses from PAGE_BASE, with these offsets: 0 fine, 1 coarse high byte, 2 coarse low byte, 3 gain, 4 clock divide. A read outside the page returns zero.
- R4: A frame start that arrives while a burst is open, or in the same cycle as a page write, makes no transfer. The transfer is deferred to a later frame start.
- R5: The pending flag rises in the cycle after any page write. It falls in the cycle after the frame start that performs the transfer, and at no other time.
- R6: Reading a page address returns the last value written there, not the active (clipped) value.
- R7: At transfer, coarse values above COARSE_MAX, fine values above FINE_MAX and gain values above GAIN_MAX become that maximum.
- R8: Clock divide keeps only bits [3:0] of the written byte; bits [7:4] are ignored and read back as zero. At transfer, values above CLKDIV_MAX become CLKDIV_MAX.
- R9: A burst opens with a page write. It closes on a bus STOP pulse or on a write outside the page, whichever comes first.
- R10: wr_ready is high whenever reset is released, so every valid beat is accepted in its cycle.
- R11: After reset, all holding, staged and active values are zero and the pending flag is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat accepted (always high out of reset) |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 8 | Write byte |
| bus_stop | input | 1 | One-cycle pulse on a bus STOP condition |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Holding value at rd_addr (combinational) |
| act_coarse | output | 16 | Active coarse exposure |
| act_fine | output | 8 | Active fine exposure |
| act_clkdiv | output | 4 | Active clock divider |
| act_gain | output | 8 | Active analog gain |
| exp_pending | output | 1 | Written set not yet taken by the core |

## Verification
The hardest case to reach is a burst that straddles a frame boundary. Part of the set is written, a frame start then arrives while the burst is open, and the rest of the set follows. The bench builds this case from single-cycle steps in which write, STOP and frame-start pulses can be combined in any cycle, including a page write and a frame start on the same edge. The gain lag is exposed by the sweeps, which walk a value through the stage register and check the outputs after each of two successive frame starts.

// File: rtl/exp_shadow_pkg.sv
package exp_shadow_pkg;
  localparam int COARSE_W = 16;
  localparam int FINE_W   = 8;
  localparam int CLKDIV_W = 4;
  localparam int GAIN_W   = 8;
  localparam int BYTE_W   = 8;
  localparam int PAGE_BYTES = 5;

  localparam int OFF_FINE      = 0;
  localparam int OFF_COARSE_HI = 1;
  localparam int OFF_COARSE_LO = 2;
  localparam int OFF_GAIN      = 3;
  localparam int OFF_CLKDIV    = 4;

  typedef struct packed {
    logic [COARSE_W-1:0] coarse;
    logic [FINE_W-1:0]   fine;
    logic [CLKDIV_W-1:0] clkdiv;
    logic [GAIN_W-1:0]   gain;
  } exp_set_t;
endpackage

// File: rtl/exp_hold_regs.sv
module exp_hold_regs
  import exp_shadow_pkg::*;
#(
  parameter int                 ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]  PAGE_BASE = 8'h20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [BYTE_W-1:0]   rd_data,
  output logic                page_we,
  output logic                other_we,
  output exp_set_t            hold_set
);
  localparam logic [ADDR_W-1:0] NBYTES = ADDR_W'(PAGE_BYTES);

  logic [ADDR_W-1:0] wr_off, rd_off;
  logic [BYTE_W-1:0] hold_q [PAGE_BYTES];

  assign wr_off   = wr_addr - PAGE_BASE;
  assign rd_off   = rd_addr - PAGE_BASE;
  assign page_we  = wr_valid && (wr_off < NBYTES);
  assign other_we = wr_valid && !(wr_off < NBYTES);

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
    localparam logic [BYTE_W-1:0] KEEP =
      (i == OFF_CLKDIV) ? BYTE_W'((1 << CLKDIV_W) - 1) : '1;
    always_ff @(posedge clk) begin
      if (!rst_n)
        hold_q[i] <= '0;
      else if (page_we && wr_off == ADDR_W'(i))
        hold_q[i] <= wr_data & KEEP;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < PAGE_BYTES; i++)
      if (rd_off == ADDR_W'(i)) rd_data = hold_q[i];
  end

  assign hold_set.coarse = {hold_q[OFF_COARSE_HI], hold_q[OFF_COARSE_LO]};
  assign hold_set.fine   = hold_q[OFF_FINE];
  assign hold_set.clkdiv = hold_q[OFF_CLKDIV][CLKDIV_W-1:0];
  assign hold_set.gain   = hold_q[OFF_GAIN];
endmodule

// File: rtl/exp_burst_tracker.sv
module exp_burst_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic page_we,
  input  logic other_we,
  input  logic bus_stop,
  input  logic frame_start,
  output logic xfer,
  output logic pending
);
  logic burst_q, pending_q;

  // A transfer needs a frame start, an unconsumed set, no open burst
  // and no page write arriving on the same edge.
  assign xfer    = frame_start && pending_q && !burst_q && !page_we;
  assign pending = pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_q   <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      if (page_we)                    burst_q <= 1'b1;
      else if (other_we || bus_stop)  burst_q <= 1'b0;

      if (page_we)    pending_q <= 1'b1;
      else if (xfer)  pending_q <= 1'b0;
    end
  end
endmodule

// File: rtl/exp_apply_pipe.sv
module exp_apply_pipe
  import exp_shadow_pkg::*;
#(
  parameter logic [COARSE_W-1:0] COARSE_MAX = 16'd500,
  parameter logic [FINE_W-1:0]   FINE_MAX   = 8'd200,
  parameter logic [CLKDIV_W-1:0] CLKDIV_MAX = 4'd11,
  parameter logic [GAIN_W-1:0]   GAIN_MAX   = 8'd15
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     xfer,
  input  logic     frame_start,
  input  exp_set_t hold_set,
  output exp_set_t act_set
);
  exp_set_t         clipped;
  logic [GAIN_W-1:0] gain_stage_q;
  exp_set_t         act_q;

  always_comb begin
    clipped.coarse = (hold_set.coarse > COARSE_MAX) ? COARSE_MAX : hold_set.coarse;
    clipped.fine   = (hold_set.fine   > FINE_MAX)   ? FINE_MAX   : hold_set.fine;
    clipped.clkdiv = (hold_set.clkdiv > CLKDIV_MAX) ? CLKDIV_MAX : hold_set.clkdiv;
    clipped.gain   = (hold_set.gain   > GAIN_MAX)   ? GAIN_MAX   : hold_set.gain;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q        <= '0;
      gain_stage_q <= '0;
    end else begin
      if (xfer) begin
        act_q.coarse <= clipped.coarse;
        act_q.fine   <= clipped.fine;
        act_q.clkdiv <= clipped.clkdiv;
        gain_stage_q <= clipped.gain;
      end
      if (frame_start) act_q.gain <= gain_stage_q;
    end
  end

  assign act_set = act_q;
endmodule

// File: rtl/exp_shadow_sync.sv
module exp_shadow_sync
  import exp_shadow_pkg::*;
#(
  parameter int                  ADDR_W     = 8,
  parameter logic [ADDR_W-1:0]   PAGE_BASE  = 8'h20,
  parameter logic [COARSE_W-1:0] COARSE_MAX = 16'd500,
  parameter logic [FINE_W-1:0]   FINE_MAX   = 8'd200,
  parameter logic [CLKDIV_W-1:0] CLKDIV_MAX = 4'd11,
  parameter logic [GAIN_W-1:0]   GAIN_MAX   = 8'd15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                bus_stop,
  input  logic                frame_start,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [BYTE_W-1:0]   rd_data,
  output logic [COARSE_W-1:0] act_coarse,
  output logic [FINE_W-1:0]   act_fine,
  output logic [CLKDIV_W-1:0] act_clkdiv,
  output logic [GAIN_W-1:0]   act_gain,
  output logic                exp_pending
);
  logic     page_we, other_we, xfer;
  exp_set_t hold_set, act_set;

  // Writes are absorbed in one cycle, so ready only tracks reset.
  assign wr_ready = rst_n;

  exp_hold_regs #(.ADDR_W(ADDR_W), .PAGE_BASE(PAGE_BASE)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .page_we(page_we), .other_we(other_we), .hold_set(hold_set)
  );

  exp_burst_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .page_we(page_we), .other_we(other_we),
    .bus_stop(bus_stop), .frame_start(frame_start), .xfer(xfer),
    .pending(exp_pending)
  );

  exp_apply_pipe #(
    .COARSE_MAX(COARSE_MAX), .FINE_MAX(FINE_MAX),
    .CLKDIV_MAX(CLKDIV_MAX), .GAIN_MAX(GAIN_MAX)
  ) u_apply (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .frame_start(frame_start),
    .hold_set(hold_set), .act_set(act_set)
  );

  assign act_coarse = act_set.coarse;
  assign act_fine   = act_set.fine;
  assign act_clkdiv = act_set.clkdiv;
  assign act_gain   = act_set.gain;
endmodule

// File: rtl/exp_shadow_sync_chk.sv
module exp_shadow_sync_chk #(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] PAGE_BASE  = 8'h20,
  parameter logic [15:0]       COARSE_MAX = 16'd500,
  parameter logic [7:0]        FINE_MAX   = 8'd200,
  parameter logic [3:0]        CLKDIV_MAX = 4'd11,
  parameter logic [7:0]        GAIN_MAX   = 8'd15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              frame_start,
  input logic [15:0]       act_coarse,
  input logic [7:0]        act_fine,
  input logic [3:0]        act_clkdiv,
  input logic [7:0]        act_gain,
  input logic              exp_pending
);
  logic [ADDR_W-1:0] off;
  logic              page_hit;
  assign off      = wr_addr - PAGE_BASE;
  assign page_hit = wr_valid && (off < ADDR_W'(5));

  AST_EXP_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable({act_coarse, act_fine, act_clkdiv})); // R1
  AST_GAIN_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_gain)); // R2
  AST_NO_XFER_ON_PAGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && page_hit) |=> $stable({act_coarse, act_fine, act_clkdiv})); // R4
  AST_PENDING_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    page_hit |=> exp_pending); // R5
  AST_PENDING_FALLS_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(exp_pending) |-> $past(frame_start)); // R5
  AST_CLIP_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (act_coarse <= COARSE_MAX) && (act_fine <= FINE_MAX) && (act_gain <= GAIN_MAX)); // R7
  AST_CLKDIV_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    act_clkdiv <= CLKDIV_MAX); // R8
endmodule

bind exp_shadow_sync exp_shadow_sync_chk #(
  .ADDR_W(ADDR_W), .PAGE_BASE(PAGE_BASE), .COARSE_MAX(COARSE_MAX),
  .FINE_MAX(FINE_MAX), .CLKDIV_MAX(CLKDIV_MAX), .GAIN_MAX(GAIN_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .frame_start(frame_start), .act_coarse(act_coarse), .act_fine(act_fine),
  .act_clkdiv(act_clkdiv), .act_gain(act_gain), .exp_pending(exp_pending)
);

// File: tb/exp_shadow_sync_tb.sv
`timescale 1ns/10ps
module exp_shadow_sync_tb;
  localparam logic [7:0] BASE = 8'h20;
  localparam int CMAX = 500, FMAX = 200, DMAX = 11, GMAX = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, bus_stop = 1'b0, frame_start = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic wr_ready, exp_pending;
  logic [7:0] rd_data, act_fine, act_gain;
  logic [15:0] act_coarse;
  logic [3:0] act_clkdiv;

  int n_vec = 0, n_bad = 0;
  int m_hold [5];
  int m_coarse = 0, m_fine = 0, m_div = 0, m_gain = 0, m_stage = 0;
  bit m_pend = 0, m_burst = 0;

  always #2 clk = ~clk;

  exp_shadow_sync u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .bus_stop(bus_stop),
    .frame_start(frame_start), .rd_addr(rd_addr), .rd_data(rd_data),
    .act_coarse(act_coarse), .act_fine(act_fine), .act_clkdiv(act_clkdiv),
    .act_gain(act_gain), .exp_pending(exp_pending)
  );

  function automatic int clip(int v, int mx);
    return (v > mx) ? mx : v;
  endfunction

  task automatic chk(string what, int act, int exp, string ctx);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", what, ctx, act, exp);
    end
  endtask

  task automatic check_all(string ctx);
    chk("R1 coarse", act_coarse, m_coarse, ctx);
    chk("R1 R7 fine", act_fine, m_fine, ctx);
    chk("R8 clkdiv", act_clkdiv, m_div, ctx);
    chk("R2 gain", act_gain, m_gain, ctx);
    chk("R5 pending", exp_pending, m_pend, ctx);
    for (int i = 0; i < 5; i++) begin
      rd_addr = BASE + 8'(i);
      #0.1;
      chk("R6 readback", rd_data, m_hold[i], ctx);
    end
    rd_addr = BASE + 8'd5;
    #0.1;
    chk("R3 outside read", rd_data, 0, ctx);
  endtask

  // One clock: drive at negedge, model the edge, check at next negedge.
  task automatic step(bit wv, logic [7:0] a, logic [7:0] d, bit fs, bit st, string ctx);
    bit in_pg, xf;
    int off;
    wr_valid = wv; wr_addr = a; wr_data = d; frame_start = fs; bus_stop = st;
    #0.1;
    if (wv) chk("R10 ready", wr_ready, 1, ctx);
    @(posedge clk);
    off = int'(a) - int'(BASE);
    in_pg = wv && off >= 0 && off < 5;
    xf = fs && m_pend && !m_burst && !in_pg;
    if (fs) begin
      m_gain = m_stage;
      if (xf) begin
        m_coarse = clip(m_hold[1] * 256 + m_hold[2], CMAX);
        m_fine   = clip(m_hold[0], FMAX);
        m_div    = clip(m_hold[4], DMAX);
        m_stage  = clip(m_hold[3], GMAX);
      end
    end
    if (in_pg) m_hold[off] = (off == 4) ? (int'(d) % 16) : int'(d);
    if (in_pg) m_pend = 1; else if (xf) m_pend = 0;
    if (in_pg) m_burst = 1; else if (wv || st) m_burst = 0;
    @(negedge clk);
    wr_valid = 0; frame_start = 0; bus_stop = 0;
    check_all(ctx);
  endtask

  task automatic wr(int off, int d, string ctx);
    step(1, BASE + 8'(off), 8'(d), 0, 0, ctx);
  endtask
  task automatic stop(string ctx);  step(0, 8'h00, 8'h00, 0, 1, ctx); endtask
  task automatic frame(string ctx); step(0, 8'h00, 8'h00, 1, 0, ctx); endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) m_hold[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R11 reset state");

    // Full burst then STOP: nothing active until a frame start (R1).
    wr(0, 100, "R1 burst"); wr(1, 1, "R1 burst"); wr(2, 44, "R1 burst");
    wr(3, 9, "R1 burst"); wr(4, 7, "R1 burst");
    stop("R9 stop closes burst");
    step(0, 8'h00, 8'h00, 0, 0, "R1 idle no change");
    frame("R2 exposure first");
    frame("R2 gain one frame later");

    // Burst straddling a frame start (R4).
    wr(0, 50, "R4 partial"); wr(1, 0, "R4 partial");
    frame("R4 deferred in burst");
    wr(2, 200, "R4 rest"); wr(3, 3, "R4 rest"); wr(4, 2, "R4 rest");
    frame("R4 still open");
    stop("R9 stop");
    frame("R4 full set taken");
    frame("R2 gain follows");

    // Page write on the same edge as a frame start (R4).
    wr(3, 5, "R4 setup"); stop("R4 setup");
    step(1, BASE + 8'd0, 8'd77, 1, 0, "R4 same-edge write");
    step(1, BASE + 8'd1, 8'd0, 0, 1, "R9 stop with page write keeps burst");
    frame("R9 burst still open");
    step(1, 8'h05, 8'd1, 0, 0, "R9 outside write closes");
    frame("R5 transfer clears pending");
    frame("R2 gain");

    // Gain sweep (R7).
    for (int g = 0; g < 32; g++) begin
      wr(3, g, "R7 gain sweep"); stop("R7 gain sweep");
      frame("R7 gain sweep"); frame("R2 R7 gain sweep");
    end
    // Clock divide sweep including upper nibble (R8).
    for (int v = 0; v < 40; v++) begin
      wr(4, v * 7, "R8 div sweep"); stop("R8 div sweep");
      frame("R8 div sweep");
    end
    // Fine sweep around limit (R7).
    for (int v = 190; v < 212; v++) begin
      wr(0, v, "R7 fine sweep"); stop("R7 fine sweep"); frame("R7 fine sweep");
    end
    // Coarse sweep around limit 0x01F4 (R7).
    for (int h = 0; h < 4; h++) begin
      for (int l = 0; l < 4; l++) begin
        int lo;
        lo = (l == 0) ? 0 : (l == 1) ? 8'hF3 : (l == 2) ? 8'hF4 : 8'hFF;
        wr(1, h, "R7 coarse sweep"); wr(2, lo, "R7 coarse sweep");
        stop("R7 coarse sweep"); frame("R7 coarse sweep");
      end
    end
    // Mid-run reset returns everything to zero (R11).
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 5; i++) m_hold[i] = 0;
    m_coarse = 0; m_fine = 0; m_div = 0; m_gain = 0; m_stage = 0;
    m_pend = 0; m_burst = 0;
    check_all("R11 reset again");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule